// File: doc/BRIEF.md
# Keyed Frequency Hop Sequence Generator

This block derives the channel order for a frequency-hopping radio link from a 32-bit link identifier. A start pulse seeds a pseudo-random generator with the identifier. The block then tests one candidate channel per clock, taken from a space of 125 channel numbers. A candidate joins the list only if two conditions hold: the list does not already contain it, and the candidate's band is still below its quota. Generation ends when the list holds 23 channels.

The finished list stays in an internal table, and a combinational index port reads it. Both ends of a link run the same generator with the same identifier, so both obtain the same ordered list. The band quotas keep the hop set spread across the whole spectrum. A done flag tells the hop timer that the list is ready. The table then stays frozen until the next start.

Top module: `hop_seq_gen`

## Requirements
- R1: A start pulse while busy is low begins a run. On the next cycle busy is high, done is low, and the accepted-channel count is zero.
- R2: The generator is a 32-bit Galois LFSR that shifts right and XORs in mask 32'hA300_0000 when the bit shifted out is 1. It is loaded with the identifier, or with 32'h1D87_2B41 if the identifier is zero. Each busy cycle tests the candidate (state mod 125) and then advances the state, so the first candidate comes from the loaded seed.
- R3: A candidate equal to a channel already in the list is discarded.
- R4: The band of a channel is its number shifted right by 5 (0–31, 32–63, 64–95, 96–124). Bands 0 to 2 accept at most 6 channels and band 3 at most 5. A candidate whose band is full is discarded.
- R5: Accepted channels are written at indices 0 to 22 in order of acceptance. rd_ch returns the entry at rd_idx in the same cycle, and returns 0 for any rd_idx of 23 or above.
- R6: On the edge that accepts the 23rd channel, done rises and busy falls together. Done then stays high until the next accepted start.
- R7: A start pulse while busy is high is ignored, including one that coincides with the final acceptance.
- R8: While done is high and no start arrives, the table contents do not change, even if link_id changes.
- R9: After reset, busy and done are low and every table entry reads 0.
- R10: Two runs with the same identifier produce identical lists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin generation pulse, honoured only while idle |
| link_id | input | 32 | Link identifier used as seed |
| rd_idx | input | 5 | Table read index |
| rd_ch | output | 7 | Channel at rd_idx |
| busy | output | 1 | Generation in progress |
| done | output | 1 | List complete and frozen |

## Verification
Two events can land on the same clock edge: a start request and the acceptance of the 23rd channel. The bench uses its reference model to find the exact cycle count of a run. It raises start with a different identifier on precisely the completing edge. The run passes if done still rises on that edge, busy falls, and the table holds the first identifier's list. A second start, placed early in a run, checks the same rule in the middle of generation.

// File: rtl/hop_pkg.sv
// Shared constants and the generator step function for the hop sequence block.
// Assumes a 32-bit state; the mask gives a long right-shift Galois sequence.
package hop_pkg;
    localparam int          STATE_W   = 32;
    localparam logic [31:0] STEP_MASK = 32'hA300_0000;
    localparam logic [31:0] ZERO_SUB  = 32'h1D87_2B41;

    // One right-shift Galois step.
    function automatic logic [STATE_W-1:0] galois_step(input logic [STATE_W-1:0] s);
        return (s >> 1) ^ (s[0] ? STEP_MASK : '0);
    endfunction
endpackage

// File: rtl/hop_lfsr.sv
// Pseudo-random state register. Loads the seed on load (zero seed replaced by
// a fixed constant so the state never locks at zero) and steps while step is high.
module hop_lfsr
    import hop_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [STATE_W-1:0] seed,
    output logic [STATE_W-1:0] state
);
    logic [STATE_W-1:0] state_q;

    // Hold, reload or advance the generator state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ZERO_SUB;
        else if (load)
            state_q <= (seed == '0) ? ZERO_SUB : seed;
        else if (step)
            state_q <= galois_step(state_q);
    end

    assign state = state_q;
endmodule

// File: rtl/hop_band_quota.sv
// Per-band acceptance counters. Reports whether the band of the current
// candidate still has room. Assumes NUM_BANDS is a power of two.
module hop_band_quota #(
    parameter int NUM_BANDS  = 4,
    parameter int QUOTA_MAIN = 6,
    parameter int QUOTA_LAST = 5,
    localparam int BAND_W    = $clog2(NUM_BANDS),
    localparam int CNT_W     = $clog2(QUOTA_MAIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [BAND_W-1:0] band,
    output logic              room
);
    logic [NUM_BANDS-1:0] has_room;

    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
        localparam int LIMIT = (b == NUM_BANDS - 1) ? QUOTA_LAST : QUOTA_MAIN;
        logic [CNT_W-1:0] cnt_q;

        // Count acceptances landing in this band.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                cnt_q <= '0;
            else if (inc && band == BAND_W'(b))
                cnt_q <= cnt_q + 1'b1;
        end

        assign has_room[b] = (cnt_q < CNT_W'(LIMIT));
    end

    assign room = has_room[band];
endmodule

// File: rtl/hop_table.sv
// Channel list storage plus an occupancy bitmap for duplicate detection.
// The bitmap clears on clr; list entries are only overwritten by wr.
module hop_table #(
    parameter int NUM_CH   = 125,
    parameter int SEQ_LEN  = 23,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int IDX_W   = $clog2(SEQ_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CH_W-1:0]  cand,
    output logic             taken,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CH_W-1:0]  rd_ch
);
    logic [CH_W-1:0]   mem_q [SEQ_LEN];
    logic [NUM_CH-1:0] used_q;

    // Mark channels already placed in the list.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            used_q <= '0;
        else if (wr)
            used_q[cand] <= 1'b1;
    end

    // Store accepted channels in acceptance order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEQ_LEN; i++) mem_q[i] <= '0;
        end else if (wr) begin
            mem_q[wr_idx] <= cand;
        end
    end

    assign taken = used_q[cand];
    assign rd_ch = (rd_idx < IDX_W'(SEQ_LEN)) ? mem_q[rd_idx] : '0;
endmodule

// File: rtl/hop_seq_gen.sv
// Top: sequences one candidate per clock from start until SEQ_LEN channels
// are accepted. Assumes 3*QUOTA_MAIN + QUOTA_LAST == SEQ_LEN and that the
// last band is the one short of a full 2**BAND_SHIFT span.
module hop_seq_gen
    import hop_pkg::*;
#(
    parameter int NUM_CH     = 125,
    parameter int SEQ_LEN    = 23,
    parameter int NUM_BANDS  = 4,
    parameter int BAND_SHIFT = 5,
    parameter int QUOTA_MAIN = 6,
    parameter int QUOTA_LAST = 5,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int IDX_W     = $clog2(SEQ_LEN),
    localparam int FILL_W    = $clog2(SEQ_LEN + 1),
    localparam int BAND_W    = $clog2(NUM_BANDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [STATE_W-1:0] link_id,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CH_W-1:0]    rd_ch,
    output logic               busy,
    output logic               done
);
    logic [STATE_W-1:0] state;
    logic [CH_W-1:0]    cand;
    logic [BAND_W-1:0]  band;
    logic               taken, room, acc, start_ok;
    logic               busy_q, done_q;
    logic [FILL_W-1:0]  fill_q;

    assign start_ok = start && !busy_q;
    assign cand     = CH_W'(state % STATE_W'(NUM_CH));
    assign band     = BAND_W'(cand >> BAND_SHIFT);
    assign acc      = busy_q && !taken && room;

    hop_lfsr i_lfsr (
        .clk(clk), .rst_n(rst_n), .load(start_ok), .step(busy_q),
        .seed(link_id), .state(state)
    );

    hop_band_quota #(
        .NUM_BANDS(NUM_BANDS), .QUOTA_MAIN(QUOTA_MAIN), .QUOTA_LAST(QUOTA_LAST)
    ) i_quota (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .inc(acc),
        .band(band), .room(room)
    );

    hop_table #(.NUM_CH(NUM_CH), .SEQ_LEN(SEQ_LEN)) i_table (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .wr(acc),
        .wr_idx(IDX_W'(fill_q)), .cand(cand), .taken(taken),
        .rd_idx(rd_idx), .rd_ch(rd_ch)
    );

    // Run control: start, count acceptances, finish on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            fill_q <= '0;
        end else if (start_ok) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            fill_q <= '0;
        end else if (acc) begin
            fill_q <= fill_q + 1'b1;
            if (fill_q == FILL_W'(SEQ_LEN - 1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
endmodule

// File: rtl/hop_seq_chk.sv
// Property checker for hop_seq_gen, bound onto every instance of it.
module hop_seq_chk #(
    parameter int NUM_CH  = 125,
    parameter int SEQ_LEN = 23,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int FILL_W = $clog2(SEQ_LEN + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              acc,
    input logic [FILL_W-1:0] fill,
    input logic [CH_W-1:0]   cand
);
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && fill == '0));                  // R1
    AST_CAND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cand < CH_W'(NUM_CH)));                                      // R2
    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && acc) |=> (fill == $past(fill) + 1'b1));                       // R5
    AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && fill == FILL_W'(SEQ_LEN)));                         // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && fill != '0) |=> (fill != '0));                       // R7
    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(fill)));                         // R8
endmodule

bind hop_seq_gen hop_seq_chk #(.NUM_CH(NUM_CH), .SEQ_LEN(SEQ_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .acc(acc), .fill(fill_q), .cand(cand)
);

// File: tb/test_hop_seq_gen.sv
module test_hop_seq_gen;
    localparam logic [31:0] B_MASK = 32'hA300_0000;
    localparam logic [31:0] B_ZSUB = 32'h1D87_2B41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] link_id = '0;
    logic [4:0]  rd_idx = '0;
    logic [6:0]  rd_ch;
    logic        busy, done;

    int n_vec = 0;
    int n_bad = 0;
    int exp_seq [23];
    int exp_cyc;
    int saved [23];

    hop_seq_gen i_hop_seq_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .link_id(link_id),
        .rd_idx(rd_idx), .rd_ch(rd_ch), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    function automatic void chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    // Reference list built from the requirements.
    function automatic void ref_gen(input logic [31:0] id);
        logic [31:0] s = (id == 0) ? B_ZSUB : id;
        bit used [125];
        int bc [4] = '{0, 0, 0, 0};
        int n = 0;
        exp_cyc = 0;
        foreach (used[i]) used[i] = 1'b0;
        while (n < 23 && exp_cyc < 100000) begin
            int c = int'(s % 125);
            int b = c / 32;
            int q = (b == 3) ? 5 : 6;
            exp_cyc++;
            if (!used[c] && bc[b] < q) begin
                used[c] = 1'b1; bc[b]++; exp_seq[n] = c; n++;
            end
            s = (s >> 1) ^ (s[0] ? B_MASK : 32'h0);
        end
    endfunction

    task automatic rd(input int idx, output int ch);
        rd_idx = 5'(idx);
        #1;
        ch = int'(rd_ch);
    endtask

    task automatic kick(input logic [31:0] id);
        @(negedge clk);
        start = 1'b1; link_id = id;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Compare the whole table with exp_seq and check its rules.
    task automatic check_table(input string tag);
        int ch;
        int bc [4] = '{0, 0, 0, 0};
        bit seen [125];
        int dups = 0;
        foreach (seen[i]) seen[i] = 1'b0;
        for (int i = 0; i < 23; i++) begin
            rd(i, ch);
            chk(ch == exp_seq[i], {"R5 entry ", tag}, ch, exp_seq[i]);
            if (ch < 125) begin
                if (seen[ch]) dups++;
                seen[ch] = 1'b1;
                bc[ch / 32]++;
            end
        end
        chk(dups == 0, {"R3 duplicates ", tag}, dups, 0);
        for (int b = 0; b < 4; b++)
            chk(bc[b] <= ((b == 3) ? 5 : 6), {"R4 band quota ", tag}, bc[b], (b == 3) ? 5 : 6);
    endtask

    task automatic run_case(input logic [31:0] id, input string tag);
        int k = 0;
        int ch;
        ref_gen(id);
        kick(id);
        chk(busy && !done, {"R1 busy after start ", tag}, {busy, done}, 2);
        while (k < 5000) begin
            @(posedge clk); k++;
            @(negedge clk);
            if (done) break;
        end
        chk(k == exp_cyc, {"R6 cycles to done ", tag}, k, exp_cyc);
        chk(done && !busy, {"R6 done/busy ", tag}, {done, busy}, 2);
        check_table(tag);
        rd(23, ch); chk(ch == 0, {"R5 index 23 ", tag}, ch, 0);
        rd(31, ch); chk(ch == 0, {"R5 index 31 ", tag}, ch, 0);
    endtask

    initial begin
        int ch, bad;
        logic [31:0] ida, idb;
        process::self().srandom(32'd7741);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done, "R9 reset flags", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 23; i++) begin rd(i, ch); if (ch != 0) bad++; end
        chk(bad == 0, "R9 reset table zero", bad, 0);

        // Directed corner cases
        run_case(32'h0, "zero id R2");
        run_case(32'h1, "id 1");
        run_case(32'hFFFF_FFFF, "all ones");
        run_case(32'h1234_5678, "fixed");

        // R10: same identifier twice gives the same list
        for (int i = 0; i < 23; i++) begin rd(i, ch); saved[i] = ch; end
        run_case(32'hDEAD_0001, "other");
        run_case(32'h1234_5678, "repeat");
        bad = 0;
        for (int i = 0; i < 23; i++) begin rd(i, ch); if (ch != saved[i]) bad++; end
        chk(bad == 0, "R10 determinism", bad, 0);

        // R8: frozen after done while link_id wanders
        @(negedge clk);
        link_id = 32'hCAFE_F00D;
        repeat (10) @(negedge clk);
        chk(done && !busy, "R8 done held", {done, busy}, 2);
        check_table("R8 frozen");

        // R7: start in the middle of a run is ignored
        ida = $urandom; idb = $urandom;
        ref_gen(ida);
        kick(ida);
        @(negedge clk); start = 1'b1; link_id = idb;
        @(posedge clk); @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        check_table("R7 mid-run start");

        // R7: start on the completing edge is ignored
        ida = $urandom; idb = ~ida;
        ref_gen(ida);
        kick(ida);
        repeat (exp_cyc - 1) @(posedge clk);
        @(negedge clk); start = 1'b1; link_id = idb;
        @(posedge clk); @(negedge clk); start = 1'b0;
        chk(done && !busy, "R7 done on colliding edge", {done, busy}, 2);
        @(negedge clk);
        chk(done && !busy, "R7 no restart after collision", {done, busy}, 2);
        check_table("R7 collision");

        // Random identifiers
        for (int r = 0; r < 20; r++) run_case($urandom, "random");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule